// File: doc/BRIEF.md
# Two-Phase Interleaved Center-Aligned PWM Generator

This block drives the two power switches of an interleaved boost stage. One shared up/down time base produces two center-aligned pulse trains. The second train is shifted by half a PWM period, so the two switches conduct in alternation and the ripple of the summed input current is reduced. Each channel takes its own duty word. That word is buffered and only takes effect at defined half-period reload points. The block pulses a sync output at every reload point so that downstream sampling logic can acquire currents and voltages at a fixed position in the switching period.

A protection input blanks both outputs in the same cycle it is raised. The blanking clears by itself at the next period start once the input has gone low. If fault events keep arriving, a counter of rising fault edges over a window of whole PWM periods latches both outputs off. Only an explicit clear pulse releases that latch. Polarity is active-high. Both outputs stay low while the block is disabled.

Top module: `ileave_pwm`

## Requirements
- R1: While `rst_n` is low or `en` is low, `pwm_a`, `pwm_b` and `sync_out` are 0. While disabled, the position counter is held at 0 and each channel's working duty follows its input.
- R2: When enabled, a position counter runs 0..2*HALF-1 and wraps, so the period is 2*HALF cycles. Define the triangle value t = pos for pos < HALF, and t = 2*HALF-1-pos otherwise. `pwm_a` is high exactly when t >= HALF - duty. This gives 2*duty high cycles per period, at positions HALF-duty through HALF+duty-1.
- R3: `pwm_b` is high exactly when t < duty. This gives 2*duty high cycles centered on the period wrap, at positions 0..duty-1 and 2*HALF-duty..2*HALF-1, which is 180 degrees from `pwm_a`.
- R4: Duty words above HALF are treated as HALF. A duty of 0 gives a constant low output and a duty of HALF gives a constant high output.
- R5: Half-period boundaries are the cycles with pos = HALF-1 and pos = 2*HALF-1. With `rate_sel` = r (0..15), every (r+1)-th boundary is a reload point. `sync_out` is high for exactly that cycle.
- R6: A channel changes its working duty only on the clock edge that leaves its own valley boundary: pos 2*HALF-1 for A, pos HALF-1 for B. At a reload point on its own valley, the channel takes the current input. At a reload point on the other boundary, it captures the input and applies it at its next valley. Input changes between reload points have no effect.
- R7: While `fault_in` is 1, both outputs are 0 in the same cycle. After `fault_in` was 1, the outputs stay 0 until the cycle with pos = 2*HALF-1 has been passed with `fault_in` low. Output resumes at pos 0.
- R8: Rising edges of `fault_in` are counted, saturating at 15. The count restarts every WIN PWM periods, counted from enable. When `fault_limit` is nonzero and the count reaches `fault_limit`, both outputs latch to 0. A `fault_limit` of 0 disables the latch.
- R9: The fault latch is released only by a `fault_clr` pulse. It survives disabling and re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the time base and outputs low |
| rate_sel | input | 4 | Reload every rate_sel+1 half-periods |
| duty_a | input | 15 | Requested duty of channel A, in half-period counts |
| duty_b | input | 15 | Requested duty of channel B, in half-period counts |
| fault_in | input | 1 | Synchronous protection input, active high |
| fault_clr | input | 1 | Releases the persistent-fault latch and clears the event count |
| fault_limit | input | 4 | Number of fault edges per window that latches off; 0 disables |
| pwm_a | output | 1 | Channel A switch drive, centered mid-period |
| pwm_b | output | 1 | Channel B switch drive, centered on the period wrap |
| sync_out | output | 1 | One-cycle pulse at every reload point |

## Verification
A corrupted position counter or reload-interval counter shows up within one half-period: a pulse moves off center or `sync_out` fires at a boundary where it should not. A working duty register that is loaded at the wrong edge changes the high count of the next period, and that count is compared against 2*duty. A blanking flag or fault latch stuck in the wrong state shows up as a pulse that is missing or present in the very next period. The bench compares every output on every cycle against an independent cycle model and also counts pulse widths, pulse centers and syncs per period.

// File: rtl/ileave_pwm_pkg.sv
// Package: shared widths and types for the interleaved PWM generator.
// Assumes a 15-bit duty/compare path and a 4-bit reload and event field.
package ileave_pwm_pkg;
    localparam int DUTY_W = 15;
    localparam int RATE_W = 4;
    localparam int EVT_W  = 4;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [DUTY_W:0]   pos_t;
endpackage

// File: rtl/ileave_timebase.sv
// Shared time base: position counter over one full PWM period, the folded
// triangle value used by both comparators, half-period boundary strobes,
// and the reload-interval counter that marks reload points.
// Assumes 2 <= HALF <= 2**DUTY_W - 1.
module ileave_timebase
    import ileave_pwm_pkg::*;
#(
    parameter int HALF = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_sel,
    output duty_t             tri_v,
    output logic              end_full,
    output logic              end_half,
    output logic              reload
);
    localparam pos_t LAST = pos_t'(2 * HALF - 1);
    localparam pos_t MID  = pos_t'(HALF - 1);

    pos_t              pos;
    pos_t              mirror;
    logic [RATE_W-1:0] hc;
    logic              bnd;

    // Position within the period; held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pos <= '0;
        else if (!en || pos == LAST) pos <= '0;
        else                         pos <= pos + pos_t'(1);
    end

    // Boundary strobes and reload decision.
    always_comb begin
        end_full = en && (pos == LAST);
        end_half = en && (pos == MID);
        bnd      = end_full || end_half;
        reload   = bnd && (hc >= rate_sel);
    end

    // Counts boundaries since the last reload point.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) hc <= '0;
        else if (bnd)      hc <= reload ? '0 : hc + RATE_W'(1);
    end

    // Fold the position into a 0..HALF-1..0 triangle.
    always_comb begin
        mirror = LAST - pos;
        tri_v  = (pos <= MID) ? pos[DUTY_W-1:0] : mirror[DUTY_W-1:0];
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    // R5
    sync_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> (pos == MID || pos == LAST));
    // R1
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pos == '0);
endmodule

// File: rtl/ileave_chan.sv
// One PWM channel: clamps the requested duty, holds a working duty and a
// pending copy, loads only at its own valley boundary, and compares the
// shared triangle. FAR=0 centers the pulse mid-period, FAR=1 centers it on
// the period wrap (180 degrees). Assumes valley/other are one-cycle strobes.
module ileave_chan
    import ileave_pwm_pkg::*;
#(
    parameter int HALF = 1000,
    parameter bit FAR  = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  duty_t duty_in,
    input  logic  valley,
    input  logic  other,
    input  logic  reload,
    input  duty_t tri_v,
    output logic  raw
);
    localparam duty_t FULL = duty_t'(HALF);

    duty_t req;
    duty_t act;
    duty_t held;
    logic  pend;

    // Saturate the request at the full-on value.
    assign req = (duty_in > FULL) ? FULL : duty_in;

    // Working duty changes only when leaving this channel's valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            held <= '0;
            pend <= 1'b0;
        end else if (!en) begin
            act  <= req;
            held <= req;
            pend <= 1'b0;
        end else if (valley && reload) begin
            act  <= req;
            pend <= 1'b0;
        end else if (valley && pend) begin
            act  <= held;
            pend <= 1'b0;
        end else if (other && reload) begin
            held <= req;
            pend <= 1'b1;
        end
    end

    // Compare variant picked by the phase parameter.
    generate
        if (!FAR) begin : g_mid
            assign raw = tri_v >= (FULL - act);
        end else begin : g_wrap
            assign raw = tri_v < act;
        end
    endgenerate

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !valley) |=> $stable(act));
    // R4
    act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act <= FULL);
endmodule

// File: rtl/ileave_fault.sv
// Fault handling: per-period blanking that clears itself at the period
// start once the input is low, plus a counter of rising fault edges over a
// window of WIN periods that sets a latch released only by a clear pulse.
// Assumes fault_in is synchronous to clk.
module ileave_fault
    import ileave_pwm_pkg::*;
#(
    parameter int WIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fault_in,
    input  logic             clr,
    input  logic [EVT_W-1:0] limit,
    input  logic             end_full,
    output logic             allow
);
    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic             fq;
    logic             blank;
    logic             latched;
    logic             rise;
    logic             wend;
    logic [EVT_W-1:0] evt;
    logic [EVT_W-1:0] evt_nx;
    logic [WIN_W-1:0] win;

    // Edge detect, window end and saturating event sum.
    always_comb begin
        rise   = fault_in && !fq;
        wend   = end_full && (win == WIN_W'(WIN - 1));
        evt_nx = (evt == {EVT_W{1'b1}}) ? evt : evt + EVT_W'(rise);
    end

    // Previous fault level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fq <= 1'b0;
        else        fq <= fault_in;
    end

    // Cycle-by-cycle blanking, cleared at a fault-free period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) blank <= 1'b0;
        else if (fault_in) blank <= 1'b1;
        else if (end_full) blank <= 1'b0;
    end

    // Period counter defining the event window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) win <= '0;
        else if (end_full) win <= wend ? '0 : win + WIN_W'(1);
    end

    // Fault edges seen in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) evt <= '0;
        else if (wend)            evt <= EVT_W'(rise);
        else                      evt <= evt_nx;
    end

    // Persistent-fault latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     latched <= 1'b0;
        else if (clr)   latched <= 1'b0;
        else if (en && limit != '0 && evt_nx >= limit) latched <= 1'b1;
    end

    assign allow = en && !blank && !fault_in && !latched;

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr) |=> latched);
    // R7
    blank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fault_in) |=> !allow);
endmodule

// File: rtl/ileave_pwm.sv
// Top: two center-aligned PWM channels, 180 degrees apart, sharing one time
// base, with buffered half-period reload, reload sync output and fault
// gating. Outputs are active-high and low whenever disabled or in reset.
module ileave_pwm
    import ileave_pwm_pkg::*;
#(
    parameter int HALF = 1000,
    parameter int WIN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic              fault_in,
    input  logic              fault_clr,
    input  logic [EVT_W-1:0]  fault_limit,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              sync_out
);
    duty_t tri_v;
    logic  end_full;
    logic  end_half;
    logic  reload;
    logic  allow;
    duty_t duty_v [2];
    logic  raw    [2];

    assign duty_v[0] = duty_a;
    assign duty_v[1] = duty_b;

    ileave_timebase #(.HALF(HALF)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rate_sel (rate_sel),
        .tri_v    (tri_v),
        .end_full (end_full),
        .end_half (end_half),
        .reload   (reload)
    );

    // Channel 0 reloads at the period wrap, channel 1 at mid-period.
    for (genvar g = 0; g < 2; g++) begin : gen_ch
        ileave_chan #(.HALF(HALF), .FAR(g == 1)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .duty_in (duty_v[g]),
            .valley  ((g == 0) ? end_full : end_half),
            .other   ((g == 0) ? end_half : end_full),
            .reload  (reload),
            .tri_v   (tri_v),
            .raw     (raw[g])
        );
    end

    ileave_fault #(.WIN(WIN)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .fault_in (fault_in),
        .clr      (fault_clr),
        .limit    (fault_limit),
        .end_full (end_full),
        .allow    (allow)
    );

    assign pwm_a    = raw[0] && allow;
    assign pwm_b    = raw[1] && allow;
    assign sync_out = reload;

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!pwm_a && !pwm_b && !sync_out));
    // R7
    fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/sim_ileave_pwm.sv
// Bench: cycle model from the requirements, directed corners, then
// seeded random duty/rate/fault traffic.
module sim_ileave_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int H   = 12;
    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [3:0]  rate;
    logic [14:0] da;
    logic [14:0] db;
    logic        flt;
    logic        clr;
    logic [3:0]  lim;
    logic        pwm_a;
    logic        pwm_b;
    logic        sync_out;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // model state
    int m_pos, m_hc, m_fq, m_blank, m_evt, m_win, m_latch;
    int m_act [2];
    int m_held[2];
    int m_pend[2];
    // measurement
    int cnt_a, cnt_b, cnt_s, first_a, b_at0, last_sync;

    always #(CLK_PERIOD/2) clk = ~clk;

    ileave_pwm #(.HALF(H), .WIN(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate),
        .duty_a(da), .duty_b(db), .fault_in(flt), .fault_clr(clr),
        .fault_limit(lim), .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(sync_out)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s pos=%0d: actual %b expected %b", tag, what, m_pos, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int clampd(input int d);
        return (d > H) ? H : d;
    endfunction

    // One cycle: check outputs against the model, then advance the model.
    task automatic step(input string tag);
        int  tv, req, evt_nx;
        bit  ef, eh, bnd, rl, ea, eb, allow, rise, wend, valley, other;
        #1;
        ef    = en && (m_pos == 2*H-1);
        eh    = en && (m_pos == H-1);
        bnd   = ef || eh;
        rl    = bnd && (m_hc >= int'(rate));
        tv    = (m_pos < H) ? m_pos : 2*H-1-m_pos;
        allow = en && !m_blank && !flt && !m_latch && rst_n;
        ea    = allow && (tv >= H - m_act[0]);
        eb    = allow && (tv < m_act[1]);
        chk(tag, "pwm_a", pwm_a, ea);
        chk(tag, "pwm_b", pwm_b, eb);
        chk(tag, "sync_out", sync_out, rl && rst_n);
        if (ea) cnt_a++;
        if (eb) cnt_b++;
        if (rl) cnt_s++;
        if (ea && first_a < 0) first_a = m_pos;
        if (eb && m_pos == 0) b_at0 = 1;
        last_sync = rl;
        if (!rst_n) begin
            m_pos = 0; m_hc = 0; m_fq = 0; m_blank = 0; m_evt = 0; m_win = 0; m_latch = 0;
            for (int c = 0; c < 2; c++) begin m_act[c] = 0; m_held[c] = 0; m_pend[c] = 0; end
        end else begin
            rise   = flt && !m_fq;
            evt_nx = (m_evt == 15) ? m_evt : m_evt + int'(rise);
            wend   = ef && (m_win == WIN-1);
            if (clr) m_latch = 0;
            else if (en && lim != 0 && evt_nx >= int'(lim)) m_latch = 1;
            if (!en || clr) m_evt = 0;
            else if (wend)  m_evt = int'(rise);
            else            m_evt = evt_nx;
            if (!en) m_win = 0;
            else if (ef) m_win = wend ? 0 : m_win + 1;
            if (!en) m_blank = 0;
            else if (flt) m_blank = 1;
            else if (ef) m_blank = 0;
            m_fq = flt;
            for (int c = 0; c < 2; c++) begin
                req    = clampd(c == 0 ? int'(da) : int'(db));
                valley = (c == 0) ? ef : eh;
                other  = (c == 0) ? eh : ef;
                if (!en) begin m_act[c] = req; m_held[c] = req; m_pend[c] = 0; end
                else if (valley && rl) begin m_act[c] = req; m_pend[c] = 0; end
                else if (valley && m_pend[c] != 0) begin m_act[c] = m_held[c]; m_pend[c] = 0; end
                else if (other && rl) begin m_held[c] = req; m_pend[c] = 1; end
            end
            if (!en) m_hc = 0;
            else if (bnd) m_hc = rl ? 0 : m_hc + 1;
            if (!en || m_pos == 2*H-1) m_pos = 0;
            else m_pos = m_pos + 1;
        end
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Align to pos 0, then count over n whole periods.
    task automatic measure(input string tag, input int n);
        while (m_pos != 0) step(tag);
        cnt_a = 0; cnt_b = 0; cnt_s = 0; first_a = -1; b_at0 = 0;
        run(tag, n * 2 * H);
    endtask

    task automatic wait_pos(input string tag, input int p);
        while (m_pos != p) step(tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; en = 1'b0; rate = '0; da = '0; db = '0;
        flt = 1'b0; clr = 1'b0; lim = '0;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        run("R1", 3);
        rst_n = 1'b1; da = 15'd5; db = 15'd3;
        run("R1", 4);

        // R2/R3/R5: basic waveform
        en = 1'b1;
        run("R2", 3 * 2 * H);
        measure("R2", 1);
        chkv("R2", "A high count", cnt_a, 10);
        chkv("R2", "A first high pos", first_a, H - 5);
        chkv("R3", "B high count", cnt_b, 6);
        chkv("R3", "B high at pos 0", b_at0, 1);
        chkv("R5", "syncs per period rate 0", cnt_s, 2);

        // R4: limits and clamp
        da = 15'd0; db = 15'(H + 7);
        run("R4", 2 * 2 * H);
        measure("R4", 1);
        chkv("R4", "A with duty 0", cnt_a, 0);
        chkv("R4", "B with duty above max", cnt_b, 2 * H);
        da = 15'(H); db = 15'd0;
        run("R4", 2 * 2 * H);
        measure("R4", 1);
        chkv("R4", "A with full duty", cnt_a, 2 * H);
        chkv("R4", "B with duty 0", cnt_b, 0);

        // R5: reload rate
        rate = 4'd3; da = 15'd4; db = 15'd4;
        run("R5", 4 * 2 * H);
        measure("R5", 2);
        chkv("R5", "syncs over two periods rate 3", cnt_s, 1);
        rate = 4'd1;
        run("R5", 2 * 2 * H);
        measure("R5", 1);
        chkv("R5", "syncs per period rate 1", cnt_s, 1);

        // R6: inputs ignored between reload points
        rate = 4'd15;
        last_sync = 0;
        while (!last_sync) step("R6");
        run("R6", 2 * 2 * H);
        da = 15'd9; db = 15'd9;
        measure("R6", 1);
        chkv("R6", "A keeps old duty", cnt_a, 8);
        chkv("R6", "B keeps old duty", cnt_b, 8);
        run("R6", 8 * 2 * H);
        measure("R6", 1);
        chkv("R6", "A takes new duty", cnt_a, 18);
        chkv("R6", "B takes new duty", cnt_b, 18);

        // Random traffic, latch disabled (R8: limit 0)
        lim = 4'd0;
        for (int i = 0; i < 250; i++) begin
            da   = 15'($urandom_range(0, H + 3));
            db   = 15'($urandom_range(0, H + 3));
            rate = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 3));
            for (int k = 0, n = $urandom_range(1, 40); k < n; k++) begin
                flt = ($urandom_range(0, 29) == 0);
                step("R2");
            end
        end
        flt = 1'b0;

        // R7: cycle-by-cycle blanking
        rate = 4'd0; da = 15'd6; db = 15'd6;
        run("R7", 2 * 2 * H);
        wait_pos("R7", H - 3);
        flt = 1'b1;
        run("R7", 2);
        flt = 1'b0;
        cnt_a = 0;
        while (m_pos != 0) step("R7");
        chkv("R7", "A stays blanked to period end", cnt_a, 0);
        measure("R7", 1);
        chkv("R7", "A resumes next period", cnt_a, 12);
        chkv("R8", "no latch with limit 0", cnt_b, 12);

        // R8: persistent fault latch
        lim = 4'd2;
        wait_pos("R8", 1);
        flt = 1'b1; step("R8"); flt = 1'b0; step("R8");
        flt = 1'b1; step("R8"); flt = 1'b0; step("R8");
        run("R8", 2 * H);
        measure("R8", 2);
        chkv("R8", "A latched off", cnt_a, 0);
        chkv("R8", "B latched off", cnt_b, 0);

        // R9: latch survives disable, released by clear
        en = 1'b0; run("R9", 3); en = 1'b1;
        run("R9", 2 * H);
        measure("R9", 1);
        chkv("R9", "latch survives disable", cnt_a, 0);
        clr = 1'b1; step("R9"); clr = 1'b0;
        run("R9", 2 * H);
        measure("R9", 1);
        chkv("R9", "A after clear", cnt_a, 12);

        // R8: events in different windows do not latch
        wait_pos("R8", 1);
        flt = 1'b1; step("R8"); flt = 1'b0;
        run("R8", (WIN + 1) * 2 * H);
        wait_pos("R8", 1);
        flt = 1'b1; step("R8"); flt = 1'b0;
        run("R8", 2 * H);
        measure("R8", 1);
        chkv("R8", "window expiry prevents latch", cnt_a, 12);

        summary();
        $finish;
    end
endmodule